// File: doc/BRIEF.md
# Secondary Interrupt Controller with Pass-Through

This block collects 32 level-sensitive interrupt sources and presents one combined request to a primary interrupt controller. Software opens each source individually through an enable mask, and the combined request goes high while any enabled source is asserted. Source bit 0 is also shared with a software interrupt latch, so firmware can raise a request on its own.

For a fixed group of sources, bits 21 through 30, the block can also give the source its own wire to a matching input of the primary controller. A separate pair of set and clear registers chooses which of these wires are live. Software reaches the registers through a simple memory-mapped port in a 4 KB window. The register index is the byte address divided by four.

Top module: `sec_irq_ctrl`

## Requirements
- R1: Reading index 1 returns the raw status. Bits 31..1 are `src_i` as sampled at the previous clock edge. Bit 0 is the sampled `src_i[0]` ORed with the software latch.
- R2: Reading index 0 returns the raw status ANDed with the enable mask. Reading index 2 returns the enable mask.
- R3: Writing index 2 ORs `wdata_i` into the enable mask. Writing index 3 clears each mask bit where `wdata_i` is 1.
- R4: A nonzero write to index 4 sets the software latch, and a nonzero write to index 5 clears it. A zero write to either has no effect. Reading index 4 returns raw status bit 0 in bit 0, with every other bit 0.
- R5: Writing index 8 ORs `wdata_i & 0x7FE00000` into the pass-through enable, so only bits 21..30 can become set. Writing index 9 clears each pass-through enable bit where `wdata_i` is 1. Reading index 8 returns the pass-through enable.
- R6: `pass_o[n]` equals the live `src_i[n]` in the same cycle whenever pass-through enable bit n is set, and is 0 otherwise. Bits outside 21..30 are always 0.
- R7: `irq_o` is high exactly when the raw status ANDed with the enable mask is nonzero. It reflects every source change and every register write from the next clock edge on.
- R8: Reads of any index other than 0, 1, 2, 4 and 8 return 0. Writes to any index other than 2, 3, 4, 5, 8 and 9 change no state.
- R9: While `rst_ni` is low, the enable mask, the pass-through enable, the software latch, the sampled sources and `rdata_o` are all 0.
- R10: `rdata_o` is loaded at the clock edge on which `re_i` is high, with the state as it was before that edge, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address within the register window |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| src_i | input | 32 | Level interrupt sources |
| irq_o | output | 1 | Combined request to the primary controller |
| pass_o | output | 32 | Per-source pass-through requests |

## Verification
The assertions assume that `src_i` is already synchronous to `clk_i` and is stable around the rising edge. They also assume that the bus asserts at most one write per cycle, with the address and data valid while the strobe is high. The bench therefore changes every input only on the falling edge. Each register access lasts exactly one cycle, and a read and a write may share that cycle. Random source patterns and random register indices, including the undefined indices, are drawn within these rules.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned IX_STATUS = 0;
  localparam int unsigned IX_RAW    = 1;
  localparam int unsigned IX_EN_SET = 2;
  localparam int unsigned IX_EN_CLR = 3;
  localparam int unsigned IX_SW_SET = 4;
  localparam int unsigned IX_SW_CLR = 5;
  localparam int unsigned IX_PT_SET = 8;
  localparam int unsigned IX_PT_CLR = 9;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic pt_set;
    logic pt_clr;
  } wr_dec_t;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_STATUS,
    RS_RAW,
    RS_MASK,
    RS_SOFT,
    RS_PT
  } rd_sel_t;
endpackage

// File: rtl/sic_decode.sv
module sic_decode
  import sic_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output wr_dec_t           wr_o,
  output rd_sel_t           rsel_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  always_comb begin
    wr_o = '0;
    if (we_i) begin
      wr_o.en_set = (idx == IDX_W'(IX_EN_SET));
      wr_o.en_clr = (idx == IDX_W'(IX_EN_CLR));
      wr_o.sw_set = (idx == IDX_W'(IX_SW_SET));
      wr_o.sw_clr = (idx == IDX_W'(IX_SW_CLR));
      wr_o.pt_set = (idx == IDX_W'(IX_PT_SET));
      wr_o.pt_clr = (idx == IDX_W'(IX_PT_CLR));
    end
  end

  // the set indices double as read addresses for mask, soft bit and pass enables
  always_comb begin
    rsel_o = RS_NONE;
    if      (idx == IDX_W'(IX_STATUS)) rsel_o = RS_STATUS;
    else if (idx == IDX_W'(IX_RAW))    rsel_o = RS_RAW;
    else if (idx == IDX_W'(IX_EN_SET)) rsel_o = RS_MASK;
    else if (idx == IDX_W'(IX_SW_SET)) rsel_o = RS_SOFT;
    else if (idx == IDX_W'(IX_PT_SET)) rsel_o = RS_PT;
  end
endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PT_LO   = 21,
  parameter int unsigned PT_HI   = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  wr_dec_t            wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pten_o,
  output logic               swi_o,
  output logic [NUM_SRC-1:0] raw_o
);
  logic [NUM_SRC-1:0] pt_allow;
  logic [NUM_SRC-1:0] mask_q, pten_q, src_q;
  logic               swi_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_allow
    assign pt_allow[g] = (g >= PT_LO) && (g <= PT_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pten_q <= '0;
      swi_q  <= 1'b0;
      src_q  <= '0;
    end else begin
      src_q <= src_i;
      if (wr_i.en_set) mask_q <= mask_q | wdata_i;
      if (wr_i.en_clr) mask_q <= mask_q & ~wdata_i;
      if (wr_i.sw_set && (|wdata_i)) swi_q <= 1'b1;
      if (wr_i.sw_clr && (|wdata_i)) swi_q <= 1'b0;
      if (wr_i.pt_set) pten_q <= pten_q | (wdata_i & pt_allow);
      if (wr_i.pt_clr) pten_q <= pten_q & ~wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign pten_o = pten_q;
  assign swi_o  = swi_q;
  assign raw_o  = {src_q[NUM_SRC-1:1], src_q[0] | swi_q};
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] pten_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] pass_o
);
  assign status_o = raw_i & mask_i;
  assign irq_o    = |status_o;
  // bypass uses the live input so the parent sees it without a register stage
  assign pass_o   = src_i & pten_i;
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PT_LO   = 21,
  parameter int unsigned PT_HI   = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [NUM_SRC-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] pass_o
);
  wr_dec_t            wr_dec;
  rd_sel_t            rsel;
  logic [NUM_SRC-1:0] mask_q, pten_q, raw_q, status;
  logic               swi_q;

  sic_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .we_i   (we_i),
    .wr_o   (wr_dec),
    .rsel_o (rsel)
  );

  sic_regs #(.NUM_SRC(NUM_SRC), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_dec),
    .wdata_i (wdata_i),
    .src_i   (src_i),
    .mask_o  (mask_q),
    .pten_o  (pten_q),
    .swi_o   (swi_q),
    .raw_o   (raw_q)
  );

  sic_route #(.NUM_SRC(NUM_SRC)) u_route (
    .raw_i    (raw_q),
    .mask_i   (mask_q),
    .pten_i   (pten_q),
    .src_i    (src_i),
    .status_o (status),
    .irq_o    (irq_o),
    .pass_o   (pass_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (re_i) begin
      unique case (rsel)
        RS_STATUS: rdata_o <= status;
        RS_RAW:    rdata_o <= raw_q;
        RS_MASK:   rdata_o <= mask_q;
        RS_SOFT:   rdata_o <= {{(NUM_SRC-1){1'b0}}, raw_q[0]};
        RS_PT:     rdata_o <= pten_q;
        default:   rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_irq_ctrl_chk.sv
module sec_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PT_LO   = 21,
  parameter int unsigned PT_HI   = 30
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic               we_i,
  input logic               re_i,
  input logic [NUM_SRC-1:0] rdata_o,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pass_o,
  input logic [NUM_SRC-1:0] pten_q,
  input logic               swi_q
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  function automatic logic [NUM_SRC-1:0] allow_f();
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[i] = (i >= PT_LO) && (i <= PT_HI);
    return m;
  endfunction
  localparam logic [NUM_SRC-1:0] ALLOW = allow_f();

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  p_pt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pten_q & ~ALLOW) == '0);

  p_pass_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o & ~src_i) == '0);

  p_clr_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == IDX_W'(3) && (&wdata_i)) |=> !irq_o);

  p_swi_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == IDX_W'(4) && (|wdata_i)) |=> swi_q);

  p_soft_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && idx == IDX_W'(4)) |=> (rdata_o[NUM_SRC-1:1] == '0));

  p_undef_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && idx > IDX_W'(9)) |=> (rdata_o == '0));
endmodule

bind sec_irq_ctrl sec_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .src_i   (src_i),
  .irq_o   (irq_o),
  .pass_o  (pass_o),
  .pten_q  (pten_q),
  .swi_q   (swi_q)
);

// File: tb/sec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_irq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] src_i = '0;
  logic        irq_o;
  logic [31:0] pass_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  sec_irq_ctrl dut_i (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i,
    .rdata_o, .src_i, .irq_o, .pass_o
  );

  // reference state
  logic [31:0] m_mask, m_pten, m_src;
  logic        m_swi;

  function automatic logic [31:0] m_raw();
    return {m_src[31:1], m_src[0] | m_swi};
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a[11:2])
      10'd0:   return m_raw() & m_mask;
      10'd1:   return m_raw();
      10'd2:   return m_mask;
      10'd4:   return {31'd0, m_raw()[0]};
      10'd8:   return m_pten;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_req(logic [11:0] a);
    case (a[11:2])
      10'd0:   return "R2 R10";
      10'd1:   return "R1 R10";
      10'd2:   return "R3 R10";
      10'd4:   return "R4 R10";
      10'd8:   return "R5 R10";
      default: return "R8 R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one bus cycle, entered and left on a falling edge
  task automatic step(logic we, logic re, logic [11:0] a, logic [31:0] wd, logic [31:0] s);
    logic [31:0] exp_rd;
    we_i = we; re_i = re; addr_i = a; wdata_i = wd; src_i = s;
    exp_rd = m_read(a);
    @(posedge clk_i);
    if (we) begin
      case (a[11:2])
        10'd2: m_mask = m_mask | wd;
        10'd3: m_mask = m_mask & ~wd;
        10'd4: if (wd != 0) m_swi = 1'b1;
        10'd5: if (wd != 0) m_swi = 1'b0;
        10'd8: m_pten = m_pten | (wd & 32'h7FE0_0000);
        10'd9: m_pten = m_pten & ~wd;
        default: ;
      endcase
    end
    m_src = s;
    @(negedge clk_i);
    check("R7", {31'd0, irq_o}, {31'd0, |(m_raw() & m_mask)});
    check("R6", pass_o, s & m_pten);
    if (re) check(rd_req(a), rdata_o, exp_rd);
    we_i = 1'b0; re_i = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic        re;
    logic [3:0]  ix;
    logic [31:0] wd;
    logic [31:0] src;
  } vec_t;

  localparam vec_t VECS [20] = '{
    '{1'b1, 1'b0, 4'd2,  32'h0000_00FF, 32'h0000_0010},
    '{1'b0, 1'b1, 4'd0,  32'h0,         32'h0000_0010},
    '{1'b0, 1'b1, 4'd1,  32'h0,         32'hA5A5_0000},
    '{1'b1, 1'b1, 4'd3,  32'h0000_0010, 32'h0000_0010},
    '{1'b0, 1'b1, 4'd0,  32'h0,         32'h0000_0010},
    '{1'b1, 1'b0, 4'd8,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{1'b0, 1'b1, 4'd8,  32'h0,         32'h1234_5678},
    '{1'b1, 1'b0, 4'd9,  32'h0020_0001, 32'hFFFF_FFFF},
    '{1'b1, 1'b0, 4'd4,  32'h0,         32'h0},
    '{1'b0, 1'b1, 4'd4,  32'h0,         32'h0},
    '{1'b1, 1'b0, 4'd4,  32'h0000_0100, 32'h0},
    '{1'b0, 1'b1, 4'd4,  32'h0,         32'h8000_0000},
    '{1'b0, 1'b1, 4'd1,  32'h0,         32'h8000_0000},
    '{1'b1, 1'b0, 4'd5,  32'h0,         32'h0},
    '{1'b1, 1'b0, 4'd5,  32'h0000_0001, 32'h0},
    '{1'b1, 1'b1, 4'd2,  32'h8000_0000, 32'h8000_0000},
    '{1'b1, 1'b0, 4'd10, 32'hFFFF_FFFF, 32'h0},
    '{1'b1, 1'b0, 4'd0,  32'hFFFF_FFFF, 32'h0},
    '{1'b0, 1'b1, 4'd2,  32'h0,         32'h0},
    '{1'b0, 1'b1, 4'd3,  32'h0,         32'hFFFF_FFFF}
  };

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_mask = '0; m_pten = '0; m_src = '0; m_swi = 1'b0;
    src_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    // R9: reset state with all sources high
    check("R9", rdata_o, 32'd0);
    check("R9", pass_o, 32'd0);
    check("R9", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    src_i = '0;
    step(1'b0, 1'b1, 12'h004, 32'h0, 32'h0);
    step(1'b0, 1'b1, 12'h008, 32'h0, 32'h0);
    step(1'b0, 1'b1, 12'h020, 32'h0, 32'h0);

    foreach (VECS[i])
      step(VECS[i].we, VECS[i].re, {6'd0, VECS[i].ix, 2'b00}, VECS[i].wd, VECS[i].src);

    // R8: far undefined index read and write
    step(1'b1, 1'b0, 12'h400, 32'hFFFF_FFFF, 32'h0);
    step(1'b0, 1'b1, 12'h400, 32'h0, 32'hFFFF_FFFF);
    step(1'b0, 1'b1, 12'h008, 32'h0, 32'h0);
    step(1'b0, 1'b1, 12'h020, 32'h0, 32'h0);
    // R3: full clear drops the combined request
    step(1'b1, 1'b0, 12'h008, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1'b1, 1'b0, 12'h00C, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R6: pass-through follows the live source in the same cycle
    step(1'b1, 1'b0, 12'h020, 32'h7FE0_0000, 32'h0);
    src_i = 32'h4020_0000;
    #1 check("R6", pass_o, 32'h4020_0000);

    // random traffic against the model (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int k = 0; k < 400; k++) begin
      logic [3:0] ix;
      ix = 4'($urandom_range(0, 11));
      step(1'($urandom), 1'($urandom), {6'd0, ix, 2'b00}, $urandom, $urandom);
    end

    // R9: asynchronous reset clears state
    rst_ni = 1'b0;
    #1;
    check("R9", rdata_o, 32'd0);
    check("R9", pass_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_mask = '0; m_pten = '0; m_src = '0; m_swi = 1'b0;
    step(1'b0, 1'b1, 12'h008, 32'h0, 32'h0);
    step(1'b0, 1'b1, 12'h010, 32'h0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule